// File: doc/BRIEF.md
# Duplicated Serial Frame Checker

This block sits after bit recovery and frame alignment on a measurement link whose frames travel over two parallel serial lines. Both lines carry the same frame. The second line carries every bit inverted, and the block flips those bits back as it receives them. Each line feeds its own lane. A lane shifts the frame in one bit per clock, runs a serial CRC-32 over the payload, and checks the result against the 32-bit check field that closes the frame.

A pairing stage waits until both lanes have finished a frame. The two end strobes may be up to a set number of clocks apart. The stage then makes exactly one decision for the pair:

- If both checks pass and the payloads are bit-identical, the payload is written once to a FIFO write port.
- If a check fails, the stage reports which path failed.
- If both checks pass but the payloads differ, the stage reports a mismatch.
- If a copy has no partner within the window, the stage reports a missing copy.

Each kind of event also advances a saturating counter. The block is meant for a line rate of about one 600-bit frame per acquisition period, which leaves long idle gaps between frames.

Top module: `dual_frame_checker`

## Requirements
- R1: The bits on line B are inverted before any check or comparison. A frame sent true on line A and inverted on line B counts as two identical copies.
- R2: A frame has FRAME_BITS bits, most significant first: the payload (FRAME_BITS-32 bits), then a 32-bit check field. The check field equals the CRC register after the payload bits have been shifted through it. The CRC uses polynomial 0x04C11DB7, a preset of all ones, no reflection and no final inversion. A copy passes only if its check field matches.
- R3: When both copies pass and their payloads are equal, fifo_wr_o pulses high for one cycle. fifo_wdata_o then holds the payload, with the first received payload bit at the most significant position.
- R4: When one copy fails its check, the flag for that path (crc_err_a_o or crc_err_b_o) pulses and no FIFO write occurs. When both copies fail, both flags pulse in the same cycle.
- R5: When both copies pass but their payloads differ, mismatch_o pulses and no FIFO write occurs.
- R6: Two copies whose end strobes are at most SKEW_MAX clocks apart (default 8) are paired, whichever line finishes first. If no partner arrives within SKEW_MAX clocks, missing_o pulses for that copy. A partner that arrives later is handled as a new unpaired copy and reports missing on its own.
- R7: Each pairing or timeout produces exactly one outcome. That outcome is one of: a FIFO write, path CRC errors, a mismatch, or a missing copy. Every outcome is a single-cycle pulse.
- R8: Each of the four error flags advances its own counter by one. cnt_crc_a_o, cnt_crc_b_o, cnt_mismatch_o and cnt_missing_o hold at their all-ones value instead of wrapping.
- R9: While reset is held, every flag, write strobe and counter reads zero.
- R10: A copy whose end strobe arrives on a bit count other than FRAME_BITS fails its check, whatever its CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_vld_i | input | 1 | Line A bit valid |
| a_bit_i | input | 1 | Line A data bit (true polarity) |
| a_end_i | input | 1 | Line A last bit of frame, only together with a_vld_i |
| b_vld_i | input | 1 | Line B bit valid |
| b_bit_i | input | 1 | Line B data bit (inverted polarity) |
| b_end_i | input | 1 | Line B last bit of frame, only together with b_vld_i |
| fifo_wr_o | output | 1 | FIFO write strobe for an accepted frame |
| fifo_wdata_o | output | FRAME_BITS-32 | Accepted payload |
| crc_err_a_o | output | 1 | Line A copy failed its check |
| crc_err_b_o | output | 1 | Line B copy failed its check |
| mismatch_o | output | 1 | Both copies passed but differ |
| missing_o | output | 1 | A copy had no partner within the window |
| cnt_crc_a_o | output | CNT_W | Saturating count of line A check failures |
| cnt_crc_b_o | output | CNT_W | Saturating count of line B check failures |
| cnt_mismatch_o | output | CNT_W | Saturating count of mismatches |
| cnt_missing_o | output | CNT_W | Saturating count of missing copies |

## Verification
The checker depends on three properties of the inputs:

- An end strobe comes only together with a valid bit.
- After a frame ends, a line stays idle for at least SKEW_MAX+2 clocks before the next frame's bits begin.
- A lane's captured payload therefore stays unchanged while the pairing stage decides on it and writes it out.

The stimulus meets all three. It changes inputs only on falling clock edges, raises the end strobe only on the final valid bit of a frame, and leaves a gap of thirty or more idle clocks after each frame pair. The skew tests offset the two lines only at the start of a frame, never in the middle of one.

// File: rtl/dfc_pkg.sv
package dfc_pkg;

  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,
    PS_WAIT_A = 2'd1,
    PS_WAIT_B = 2'd2
  } pair_state_e;

  // one serial CRC step, data bit enters at the top
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                 input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

endpackage

// File: rtl/dfc_lane.sv
module dfc_lane
  import dfc_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 600,
  parameter bit          INVERT     = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bit_vld_i,
  input  logic                          bit_i,
  input  logic                          end_i,
  output logic                          done_o,
  output logic                          ok_o,
  output logic [FRAME_BITS-CRC_W-1:0]   payload_o
);

  localparam int unsigned PAY_BITS = FRAME_BITS - CRC_W;
  localparam int unsigned CNT_W    = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] PAY_CNT  = CNT_W'(PAY_BITS);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] MAX_CNT  = '1;

  logic                  b_rx;
  logic [FRAME_BITS-1:0] shreg_q, shreg_d;
  logic [CRC_W-1:0]      crc_q, crc_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  done_q, done_d;
  logic                  ok_q, ok_d;

  // polarity restore chosen per lane
  generate
    if (INVERT) begin : g_inv
      assign b_rx = ~bit_i;
    end else begin : g_true
      assign b_rx = bit_i;
    end
  endgenerate

  always_comb begin
    shreg_d = shreg_q;
    crc_d   = crc_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    ok_d    = ok_q;
    if (bit_vld_i) begin
      shreg_d = {shreg_q[FRAME_BITS-2:0], b_rx};
      if (cnt_q < PAY_CNT) begin
        crc_d = crc_step(crc_q, b_rx);
      end
      if (cnt_q != MAX_CNT) begin
        cnt_d = cnt_q + 1'b1;
      end
      if (end_i) begin
        done_d = 1'b1;
        ok_d   = (cnt_q == LAST_CNT) && (crc_q == {shreg_q[CRC_W-2:0], b_rx});
        cnt_d  = '0;
        crc_d  = CRC_INIT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= CRC_INIT;
      cnt_q  <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      crc_q  <= crc_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      ok_q   <= ok_d;
    end
  end

  // data path: no reset, clock enable on valid bits
  always_ff @(posedge clk) begin
    if (bit_vld_i) begin
      shreg_q <= shreg_d;
    end
  end

  assign done_o    = done_q;
  assign ok_o      = ok_q;
  assign payload_o = shreg_q[FRAME_BITS-1:CRC_W];

endmodule

// File: rtl/dfc_pair.sv
module dfc_pair
  import dfc_pkg::*;
#(
  parameter int unsigned PAY_BITS = 568,
  parameter int unsigned SKEW_MAX = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                done_a_i,
  input  logic                ok_a_i,
  input  logic [PAY_BITS-1:0] pay_a_i,
  input  logic                done_b_i,
  input  logic                ok_b_i,
  input  logic [PAY_BITS-1:0] pay_b_i,
  output logic                wr_o,
  output logic [PAY_BITS-1:0] wdata_o,
  output logic                err_a_o,
  output logic                err_b_o,
  output logic                mism_o,
  output logic                miss_o
);

  localparam int unsigned TMR_W = $clog2(SKEW_MAX + 1);
  localparam logic [TMR_W-1:0] SKEW_CNT = TMR_W'(SKEW_MAX);

  pair_state_e       state_q, state_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic              eval;
  logic              wr_q, wr_d;
  logic              err_a_q, err_a_d;
  logic              err_b_q, err_b_d;
  logic              mism_q, mism_d;
  logic              miss_q, miss_d;
  logic [PAY_BITS-1:0] wdata_q;

  // pairing window
  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    eval    = 1'b0;
    miss_d  = 1'b0;
    unique case (state_q)
      PS_IDLE: begin
        if (done_a_i && done_b_i) begin
          eval = 1'b1;
        end else if (done_a_i) begin
          state_d = PS_WAIT_B;
          tmr_d   = TMR_W'(1);
        end else if (done_b_i) begin
          state_d = PS_WAIT_A;
          tmr_d   = TMR_W'(1);
        end
      end
      PS_WAIT_B: begin
        if (done_b_i) begin
          eval    = 1'b1;
          state_d = PS_IDLE;
        end else if (tmr_q == SKEW_CNT) begin
          miss_d  = 1'b1;
          state_d = PS_IDLE;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      PS_WAIT_A: begin
        if (done_a_i) begin
          eval    = 1'b1;
          state_d = PS_IDLE;
        end else if (tmr_q == SKEW_CNT) begin
          miss_d  = 1'b1;
          state_d = PS_IDLE;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      default: state_d = PS_IDLE;
    endcase
  end

  // decision for a complete pair
  always_comb begin
    wr_d    = 1'b0;
    err_a_d = 1'b0;
    err_b_d = 1'b0;
    mism_d  = 1'b0;
    if (eval) begin
      if (ok_a_i && ok_b_i) begin
        if (pay_a_i == pay_b_i) begin
          wr_d = 1'b1;
        end else begin
          mism_d = 1'b1;
        end
      end else begin
        err_a_d = !ok_a_i;
        err_b_d = !ok_b_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      tmr_q   <= '0;
      wr_q    <= 1'b0;
      err_a_q <= 1'b0;
      err_b_q <= 1'b0;
      mism_q  <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      wr_q    <= wr_d;
      err_a_q <= err_a_d;
      err_b_q <= err_b_d;
      mism_q  <= mism_d;
      miss_q  <= miss_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_d) begin
      wdata_q <= pay_a_i;
    end
  end

  assign wr_o    = wr_q;
  assign wdata_o = wdata_q;
  assign err_a_o = err_a_q;
  assign err_b_o = err_b_q;
  assign mism_o  = mism_q;
  assign miss_o  = miss_q;

endmodule

// File: rtl/dfc_stats.sv
module dfc_stats #(
  parameter int unsigned N_EVT = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_EVT-1:0]            evt_i,
  output logic [N_EVT-1:0][CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  generate
    for (genvar g = 0; g < N_EVT; g++) begin : g_cnt
      logic [CNT_W-1:0] c_q, c_d;
      logic             c_en;

      assign c_en = evt_i[g] && (c_q != CNT_TOP);

      always_comb begin
        c_d = c_q;
        if (c_en) begin
          c_d = c_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          c_q <= '0;
        end else begin
          c_q <= c_d;
        end
      end

      assign cnt_o[g] = c_q;
    end
  endgenerate

endmodule

// File: rtl/dual_frame_checker.sv
module dual_frame_checker
  import dfc_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 600,
  parameter int unsigned SKEW_MAX   = 8,
  parameter int unsigned CNT_W      = 16,
  localparam int unsigned PAY_BITS  = FRAME_BITS - CRC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                a_vld_i,
  input  logic                a_bit_i,
  input  logic                a_end_i,
  input  logic                b_vld_i,
  input  logic                b_bit_i,
  input  logic                b_end_i,
  output logic                fifo_wr_o,
  output logic [PAY_BITS-1:0] fifo_wdata_o,
  output logic                crc_err_a_o,
  output logic                crc_err_b_o,
  output logic                mismatch_o,
  output logic                missing_o,
  output logic [CNT_W-1:0]    cnt_crc_a_o,
  output logic [CNT_W-1:0]    cnt_crc_b_o,
  output logic [CNT_W-1:0]    cnt_mismatch_o,
  output logic [CNT_W-1:0]    cnt_missing_o
);

  localparam int unsigned N_EVT = 4;

  logic [1:0]                 rst_sync_q;
  logic                       rst_sync_n;
  logic                       done_a, ok_a, done_b, ok_b;
  logic [PAY_BITS-1:0]        pay_a, pay_b;
  logic                       err_a, err_b, mism, miss;
  logic [N_EVT-1:0]           evt;
  logic [N_EVT-1:0][CNT_W-1:0] cnt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  dfc_lane #(.FRAME_BITS(FRAME_BITS), .INVERT(1'b0)) u_lane_a (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bit_vld_i (a_vld_i),
    .bit_i     (a_bit_i),
    .end_i     (a_end_i),
    .done_o    (done_a),
    .ok_o      (ok_a),
    .payload_o (pay_a)
  );

  dfc_lane #(.FRAME_BITS(FRAME_BITS), .INVERT(1'b1)) u_lane_b (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bit_vld_i (b_vld_i),
    .bit_i     (b_bit_i),
    .end_i     (b_end_i),
    .done_o    (done_b),
    .ok_o      (ok_b),
    .payload_o (pay_b)
  );

  dfc_pair #(.PAY_BITS(PAY_BITS), .SKEW_MAX(SKEW_MAX)) u_pair (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .done_a_i (done_a),
    .ok_a_i   (ok_a),
    .pay_a_i  (pay_a),
    .done_b_i (done_b),
    .ok_b_i   (ok_b),
    .pay_b_i  (pay_b),
    .wr_o     (fifo_wr_o),
    .wdata_o  (fifo_wdata_o),
    .err_a_o  (err_a),
    .err_b_o  (err_b),
    .mism_o   (mism),
    .miss_o   (miss)
  );

  assign evt = {miss, mism, err_b, err_a};

  dfc_stats #(.N_EVT(N_EVT), .CNT_W(CNT_W)) u_stats (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .evt_i (evt),
    .cnt_o (cnt)
  );

  assign crc_err_a_o    = err_a;
  assign crc_err_b_o    = err_b;
  assign mismatch_o     = mism;
  assign missing_o      = miss;
  assign cnt_crc_a_o    = cnt[0];
  assign cnt_crc_b_o    = cnt[1];
  assign cnt_mismatch_o = cnt[2];
  assign cnt_missing_o  = cnt[3];

endmodule

// File: rtl/dfc_checker.sv
module dfc_checker #(
  parameter int unsigned PAY_BITS = 568,
  parameter int unsigned CNT_W    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                a_vld,
  input logic                a_end,
  input logic                b_vld,
  input logic                b_end,
  input logic                fifo_wr,
  input logic [PAY_BITS-1:0] fifo_wdata,
  input logic [PAY_BITS-1:0] lane_a_pay,
  input logic [PAY_BITS-1:0] lane_b_pay,
  input logic                err_a,
  input logic                err_b,
  input logic                mism,
  input logic                miss,
  input logic [CNT_W-1:0]    cnt_a,
  input logic [CNT_W-1:0]    cnt_b,
  input logic [CNT_W-1:0]    cnt_mism,
  input logic [CNT_W-1:0]    cnt_miss
);

  localparam logic [CNT_W-1:0] TOP = '1;

  // input assumption: end strobes only on a valid bit (R2)
  assert_end_on_bit_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    a_end |-> a_vld);
  assert_end_on_bit_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    b_end |-> b_vld);

  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fifo_wr, mism, miss, (err_a || err_b)}));

  assert_write_payload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (fifo_wdata == lane_a_pay) && (fifo_wdata == lane_b_pay));

  assert_pulse_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |=> !fifo_wr);

  assert_cnt_a_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_a && cnt_a != TOP) |=> cnt_a == $past(cnt_a) + 1'b1);
  assert_cnt_a_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !err_a |=> $stable(cnt_a));
  assert_cnt_b_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_b && cnt_b != TOP) |=> cnt_b == $past(cnt_b) + 1'b1);
  assert_cnt_mism_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mism && cnt_mism != TOP) |=> cnt_mism == $past(cnt_mism) + 1'b1);
  assert_cnt_mism_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mism == TOP) |=> cnt_mism == TOP);
  assert_cnt_miss_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && cnt_miss != TOP) |=> cnt_miss == $past(cnt_miss) + 1'b1);

endmodule

bind dual_frame_checker dfc_checker #(.PAY_BITS(PAY_BITS), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .a_vld      (a_vld_i),
  .a_end      (a_end_i),
  .b_vld      (b_vld_i),
  .b_end      (b_end_i),
  .fifo_wr    (fifo_wr_o),
  .fifo_wdata (fifo_wdata_o),
  .lane_a_pay (pay_a),
  .lane_b_pay (pay_b),
  .err_a      (crc_err_a_o),
  .err_b      (crc_err_b_o),
  .mism       (mismatch_o),
  .miss       (missing_o),
  .cnt_a      (cnt_crc_a_o),
  .cnt_b      (cnt_crc_b_o),
  .cnt_mism   (cnt_mismatch_o),
  .cnt_miss   (cnt_missing_o)
);

// File: tb/dual_frame_checker_tb.sv
module dual_frame_checker_tb;

  localparam int FRAME = 600;
  localparam int PAY   = FRAME - 32;
  localparam int SKEW  = 8;
  localparam int CW    = 3;

  localparam int K_WR = 1, K_EA = 2, K_EB = 3, K_EAB = 4, K_MISM = 5, K_MISS = 6;

  logic clk, rst_n;
  logic a_vld, a_bit, a_end, b_vld, b_bit, b_end;
  logic fifo_wr;
  logic [PAY-1:0] fifo_wdata;
  logic err_a, err_b, mism, miss;
  logic [CW-1:0] c_a, c_b, c_mism, c_miss;

  int checks = 0;
  int errors = 0;
  bit mon_en = 0;

  int       q_kind[$];
  logic [PAY-1:0] q_data[$];
  string    q_req[$];
  int e_ca = 0, e_cb = 0, e_cm = 0, e_cx = 0;

  dual_frame_checker #(.FRAME_BITS(FRAME), .SKEW_MAX(SKEW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_vld_i(a_vld), .a_bit_i(a_bit), .a_end_i(a_end),
    .b_vld_i(b_vld), .b_bit_i(b_bit), .b_end_i(b_end),
    .fifo_wr_o(fifo_wr), .fifo_wdata_o(fifo_wdata),
    .crc_err_a_o(err_a), .crc_err_b_o(err_b),
    .mismatch_o(mism), .missing_o(miss),
    .cnt_crc_a_o(c_a), .cnt_crc_b_o(c_b),
    .cnt_mismatch_o(c_mism), .cnt_missing_o(c_miss)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] ref_crc(input logic [PAY-1:0] p);
    logic [31:0] c;
    logic fb;
    c = 32'hFFFF_FFFF;
    for (int i = PAY - 1; i >= 0; i--) begin
      fb = c[31] ^ p[i];
      c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
    end
    return c;
  endfunction

  function automatic logic [PAY-1:0] rnd_pay();
    logic [PAY-1:0] p;
    for (int k = 0; k < PAY; k++) p[k] = 1'($urandom_range(0, 1));
    return p;
  endfunction

  function automatic int sat_inc(input int v);
    return (v >= (1 << CW) - 1) ? v : v + 1;
  endfunction

  task automatic check(input string req, input bit ok, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_evt(input int kind, input logic [PAY-1:0] d, input string req);
    q_kind.push_back(kind);
    q_data.push_back(d);
    q_req.push_back(req);
    if (kind == K_EA || kind == K_EAB) e_ca = sat_inc(e_ca);
    if (kind == K_EB || kind == K_EAB) e_cb = sat_inc(e_cb);
    if (kind == K_MISM) e_cm = sat_inc(e_cm);
    if (kind == K_MISS) e_cx = sat_inc(e_cx);
  endtask

  task automatic drive_a(input logic [FRAME-1:0] f, input int len, input int dly);
    repeat (dly) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      a_vld = 1'b1; a_bit = f[FRAME-1-i]; a_end = (i == len - 1);
      @(negedge clk);
    end
    a_vld = 1'b0; a_bit = 1'b0; a_end = 1'b0;
  endtask

  task automatic drive_b(input logic [FRAME-1:0] f, input int len, input int dly);
    repeat (dly) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      b_vld = 1'b1; b_bit = ~f[FRAME-1-i]; b_end = (i == len - 1);
      @(negedge clk);
    end
    b_vld = 1'b0; b_bit = 1'b0; b_end = 1'b0;
  endtask

  task automatic send_pair(input logic [PAY-1:0] pa, input logic [PAY-1:0] pb,
                           input bit bad_a, input bit bad_b,
                           input int len_a, input int len_b,
                           input int dly_a, input int dly_b);
    logic [FRAME-1:0] fa, fb;
    fa = {pa, ref_crc(pa) ^ {31'b0, bad_a}};
    fb = {pb, ref_crc(pb) ^ {31'b0, bad_b}};
    fork
      if (len_a > 0) drive_a(fa, len_a, dly_a);
      if (len_b > 0) drive_b(fb, len_b, dly_b);
    join
    repeat (40) @(negedge clk);
  endtask

  // monitor: pops the scoreboard on every outcome pulse
  always @(negedge clk) begin
    if (mon_en) begin
      int kind;
      int grp;
      grp  = int'(fifo_wr) + int'(mism) + int'(miss) + int'(err_a || err_b);
      kind = 0;
      if (grp > 1) kind = 99;
      else if (fifo_wr) kind = K_WR;
      else if (err_a && err_b) kind = K_EAB;
      else if (err_a) kind = K_EA;
      else if (err_b) kind = K_EB;
      else if (mism) kind = K_MISM;
      else if (miss) kind = K_MISS;
      if (kind != 0) begin
        if (q_kind.size() == 0) begin
          check("R7", 1'b0, "unexpected outcome", kind, 0);
        end else begin
          int ek;
          logic [PAY-1:0] ed;
          string er;
          ek = q_kind.pop_front();
          ed = q_data.pop_front();
          er = q_req.pop_front();
          check(er, kind == ek, "outcome kind", kind, ek);
          if (ek == K_WR && kind == K_WR)
            check(er, fifo_wdata == ed, "payload low word",
                  longint'(fifo_wdata[31:0]), longint'(ed[31:0]));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [PAY-1:0] p, p2;
    a_vld = 0; a_bit = 0; a_end = 0;
    b_vld = 0; b_bit = 0; b_end = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R9: quiet outputs in reset
    check("R9", {fifo_wr, err_a, err_b, mism, miss} == 5'b0, "flags in reset",
          {fifo_wr, err_a, err_b, mism, miss}, 0);
    check("R9", {c_a, c_b, c_mism, c_miss} == '0, "counters in reset",
          {c_a, c_b, c_mism, c_miss}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1;

    // R1 R2 R3: clean frames, line B inverted
    for (int n = 0; n < 3; n++) begin
      p = rnd_pay();
      expect_evt(K_WR, p, "R3");
      send_pair(p, p, 0, 0, FRAME, FRAME, 0, 0);
    end
    p = '0;
    expect_evt(K_WR, p, "R1");
    send_pair(p, p, 0, 0, FRAME, FRAME, 0, 0);

    // R6: skew inside the window, either side first
    p = rnd_pay(); expect_evt(K_WR, p, "R6");
    send_pair(p, p, 0, 0, FRAME, FRAME, 0, 3);
    p = rnd_pay(); expect_evt(K_WR, p, "R6");
    send_pair(p, p, 0, 0, FRAME, FRAME, 5, 0);
    p = rnd_pay(); expect_evt(K_WR, p, "R6");
    send_pair(p, p, 0, 0, FRAME, FRAME, 0, SKEW);

    // R4: CRC failures
    p = rnd_pay(); expect_evt(K_EA, p, "R4");
    send_pair(p, p, 1, 0, FRAME, FRAME, 0, 0);
    p = rnd_pay(); expect_evt(K_EB, p, "R4");
    send_pair(p, p, 0, 1, FRAME, FRAME, 0, 0);
    p = rnd_pay(); expect_evt(K_EAB, p, "R4");
    send_pair(p, p, 1, 1, FRAME, FRAME, 0, 0);

    // R10: short frame on line A
    p = rnd_pay(); expect_evt(K_EA, p, "R10");
    send_pair(p, p, 0, 0, FRAME - 1, FRAME, 0, 0);

    // R5: both pass, payloads differ by one bit
    p = rnd_pay(); p2 = p; p2[100] = ~p2[100];
    expect_evt(K_MISM, p, "R5");
    send_pair(p, p2, 0, 0, FRAME, FRAME, 0, 0);
    check("R8", c_mism == 3'd1, "mismatch count", c_mism, 1);

    // R6: skew one past the window, and a lone copy
    p = rnd_pay();
    expect_evt(K_MISS, p, "R6");
    expect_evt(K_MISS, p, "R6");
    send_pair(p, p, 0, 0, FRAME, FRAME, 0, SKEW + 1);
    p = rnd_pay(); expect_evt(K_MISS, p, "R6");
    send_pair(p, p, 0, 0, FRAME, 0, 0, 0);

    // R8: drive the mismatch counter into saturation
    for (int n = 0; n < 8; n++) begin
      p = rnd_pay(); p2 = ~p;
      expect_evt(K_MISM, p, "R8");
      send_pair(p, p2, 0, 0, FRAME, FRAME, 0, 0);
    end

    repeat (20) @(negedge clk);
    check("R7", q_kind.size() == 0, "outcomes left pending", q_kind.size(), 0);
    check("R8", int'(c_a) == e_ca, "crc A count", c_a, e_ca);
    check("R8", int'(c_b) == e_cb, "crc B count", c_b, e_cb);
    check("R8", int'(c_mism) == e_cm, "mismatch count saturated", c_mism, e_cm);
    check("R8", int'(c_miss) == e_cx, "missing count", c_miss, e_cx);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule